// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block performs the processor-side half of taking an interrupt. When an instruction reaches the decode point and the interrupt controller is requesting service, the sequencer accepts the request. The decoded instruction is marked as dropped, so it is never executed. The sequencer then writes the status register and the program counter to a downward-growing memory stack. It raises the status register's interrupt mask to the accepted level, fetches the handler address from a vector table, and loads that address straight into the program counter.

The core drives a decode-valid strobe with the address of the instruction being decoded. The controller supplies a request, a 4-bit level and a vector number. The sequencer owns a single memory port for the duration of the entry; every access on that port completes only on a ready handshake. It writes SR, PC and SP through one-cycle write strobes. While it is busy it samples no new request. The saved PC is the dropped instruction's address, so that instruction runs again after the handler returns.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and whenever busy_o is low, mem_req_o, sp_we_o, sr_we_o and pc_we_o are all low.
- R2: In a cycle where busy_o is low and both decode_valid_i and irq_req_i are high, drop_o is high in that same cycle. busy_o is high from the next cycle and stays high until the cycle after pc_we_o.
- R3: The first memory access of an entry is a write of the sampled sr_i to address sp_i − 4.
- R4: The second memory access is a write of the sampled decode_pc_i (the dropped instruction's address) to address sp_i − 8.
- R5: Each completed stack write pulses sp_we_o, with sp_o first equal to sp_i − 4 and then equal to sp_i − 8.
- R6: When the PC write completes, sr_we_o pulses exactly once. sr_o equals the saved SR with bits [7:4] replaced by the accepted level and all other bits unchanged.
- R7: The third access is a read from vbase_i + 4 × vector number. When that read completes, pc_we_o pulses with pc_o equal to the read data. No other PC write occurs during the entry, so no delay-slot instruction is fetched.
- R8: While mem_req_o is high and mem_ready_i is low, mem_addr_o, mem_we_o and (for writes) mem_wdata_o hold their values.
- R9: While busy_o is high, changes on decode_valid_i, irq_req_i, irq_level_i, irq_vec_i, decode_pc_i, sr_i and sp_i have no effect on the entry in progress. No second drop_o is raised during that time.
- R10: While decode_valid_i is low, irq_req_i alone starts no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| decode_valid_i | input | 1 | An instruction sits at the decode point this cycle |
| decode_pc_i | input | XLEN | Address of the instruction at decode |
| irq_req_i | input | 1 | Interrupt request from the controller |
| irq_level_i | input | LVL_W | Priority level of the request |
| irq_vec_i | input | VEC_W | Vector number of the request |
| vbase_i | input | XLEN | Vector table base address |
| sr_i | input | XLEN | Current status register |
| sp_i | input | XLEN | Current stack pointer |
| drop_o | output | 1 | Suppress the decoded instruction |
| busy_o | output | 1 | Entry in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | XLEN | Byte address of the access |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| sr_we_o | output | 1 | Status register write strobe |
| sr_o | output | XLEN | New status register value |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | XLEN | New program counter |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | XLEN | New stack pointer |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 4-bit level with the mask field at bits [7:4], and an 8-bit vector number. The 8-bit vector width lets vector 255 reach the last table slot at base + 0x3FC. The 32-bit word lets stack addresses near the top of the address space be tested. The memory model in the bench inserts zero to three wait states per access, which exercises the hold rule and the single-cycle write strobes under stalls. One scenario changes every request and context input on every cycle while the entry runs, to show that only the values sampled at acceptance are used.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_SR = 2'd1,
    ST_PUSH_PC = 2'd2,
    ST_VEC     = 2'd3
  } ent_state_e;
endpackage

// File: rtl/irq_ctx_latch.sv
module irq_ctx_latch #(
  parameter int XLEN  = 32,
  parameter int LVL_W = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             sp_dec_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [LVL_W-1:0] level_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  sp_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
      vec_o   <= '0;
      pc_o    <= '0;
      sr_o    <= '0;
    end else if (cap_i) begin
      level_o <= level_i;
      vec_o   <= vec_i;
      pc_o    <= pc_i;
      sr_o    <= sr_i;
    end
  end

  // working SP: loaded at accept, stepped down per completed push
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_o <= '0;
    else if (cap_i)    sp_o <= sp_i;
    else if (sp_dec_i) sp_o <= sp_o - STEP;
  end
endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic [XLEN-1:0]  sp_cur_i,
  input  logic [XLEN-1:0]  vbase_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [XLEN-1:0]  push_addr_o,
  output logic [XLEN-1:0]  vec_addr_o
);
  localparam int              SLOT_SH = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] STEP    = XLEN'(XLEN / 8);

  always_comb begin
    push_addr_o = sp_cur_i - STEP;
    vec_addr_o  = vbase_i + (XLEN'(vec_i) << SLOT_SH);
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       decode_valid_i,
  input  logic       irq_req_i,
  input  logic       mem_ready_i,
  output ent_state_e state_o,
  output logic       cap_o,
  output logic       sp_dec_o,
  output logic       sr_upd_o,
  output logic       pc_upd_o
);
  ent_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    cap_o    = 1'b0;
    sp_dec_o = 1'b0;
    sr_upd_o = 1'b0;
    pc_upd_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (decode_valid_i && irq_req_i) begin
        cap_o = 1'b1;
        st_d  = ST_PUSH_SR;
      end
      ST_PUSH_SR: if (mem_ready_i) begin
        sp_dec_o = 1'b1;
        st_d     = ST_PUSH_PC;
      end
      ST_PUSH_PC: if (mem_ready_i) begin
        sp_dec_o = 1'b1;
        sr_upd_o = 1'b1;  // mask raised only once both words are saved
        st_d     = ST_VEC;
      end
      ST_VEC: if (mem_ready_i) begin
        pc_upd_o = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LVL_W    = 4,
  parameter int VEC_W    = 8,
  parameter int MASK_LSB = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             decode_valid_i,
  input  logic [XLEN-1:0]  decode_pc_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]  vbase_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic             drop_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             sr_we_o,
  output logic [XLEN-1:0]  sr_o,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             sp_we_o,
  output logic [XLEN-1:0]  sp_o
);
  localparam logic [XLEN-1:0] MASK_M = XLEN'((1 << LVL_W) - 1) << MASK_LSB;

  ent_state_e       state;
  logic             cap, sp_dec, sr_upd, pc_upd;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  pc_q, sr_q, sp_cur, push_addr, vec_addr;

  irq_entry_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .decode_valid_i (decode_valid_i),
    .irq_req_i      (irq_req_i),
    .mem_ready_i    (mem_ready_i),
    .state_o        (state),
    .cap_o          (cap),
    .sp_dec_o       (sp_dec),
    .sr_upd_o       (sr_upd),
    .pc_upd_o       (pc_upd)
  );

  irq_ctx_latch #(.XLEN(XLEN), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .sp_dec_i (sp_dec),
    .level_i  (irq_level_i),
    .vec_i    (irq_vec_i),
    .pc_i     (decode_pc_i),
    .sr_i     (sr_i),
    .sp_i     (sp_i),
    .level_o  (lvl_q),
    .vec_o    (vec_q),
    .pc_o     (pc_q),
    .sr_o     (sr_q),
    .sp_o     (sp_cur)
  );

  irq_addr_gen #(.XLEN(XLEN), .VEC_W(VEC_W)) u_addr (
    .sp_cur_i    (sp_cur),
    .vbase_i     (vbase_i),
    .vec_i       (vec_q),
    .push_addr_o (push_addr),
    .vec_addr_o  (vec_addr)
  );

  always_comb begin
    drop_o      = cap;
    busy_o      = (state != ST_IDLE);
    mem_req_o   = busy_o;
    mem_we_o    = (state == ST_PUSH_SR) || (state == ST_PUSH_PC);
    mem_addr_o  = (state == ST_VEC) ? vec_addr : push_addr;
    mem_wdata_o = (state == ST_PUSH_SR) ? sr_q : pc_q;
    sp_we_o     = sp_dec;
    sp_o        = push_addr;
    sr_we_o     = sr_upd;
    sr_o        = (sr_q & ~MASK_M) | ((XLEN'(lvl_q) << MASK_LSB) & MASK_M);
    pc_we_o     = pc_upd;
    pc_o        = mem_rdata_i;
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            drop_o,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_ready_i,
  input logic            sr_we_o,
  input logic            pc_we_o,
  input logic            sp_we_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !sp_we_o && !sr_we_o && !pc_we_o);

  a_r2_drop_then_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> busy_o);

  a_r9_no_drop_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !drop_o);

  a_r7_pc_ends_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> !busy_o);

  a_r7_pc_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> mem_req_o && !mem_we_o && mem_ready_i);

  a_r6_sr_with_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> sp_we_o && mem_we_o && mem_ready_i);

  a_r5_sp_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> mem_req_o && mem_we_o && mem_ready_i);

  a_r8_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && (!mem_we_o || $stable(mem_wdata_o)));
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .drop_o      (drop_o),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .sr_we_o     (sr_we_o),
  .pc_we_o     (pc_we_o),
  .sp_we_o     (sp_we_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int XLEN = 32;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            dv = 1'b0, req = 1'b0;
  logic [XLEN-1:0] dpc = '0, vbase = '0, sr = '0, sp = '0;
  logic [3:0]      lvl = '0;
  logic [7:0]      vec = '0;
  logic            drop, busy, mreq, mwe, mrdy = 1'b0;
  logic [XLEN-1:0] maddr, mwdata, mrdata = '0;
  logic            sr_we, pc_we, sp_we;
  logic [XLEN-1:0] sr_o, pc_o, sp_o;

  int nchk = 0, nerr = 0, wait_n = 0, wcnt = 0;
  bit done = 1'b0;

  logic [XLEN-1:0] wr_a [4], wr_d [4], sp_l [4], sr_l [4], pc_l [4], rd_a [4];
  int wr_n, sp_n, sr_n, pc_n, rd_n, drop_n;

  always #5 clk = ~clk;

  irq_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .decode_valid_i(dv), .decode_pc_i(dpc),
    .irq_req_i(req), .irq_level_i(lvl), .irq_vec_i(vec), .vbase_i(vbase),
    .sr_i(sr), .sp_i(sp), .drop_o(drop), .busy_o(busy), .mem_req_o(mreq),
    .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_ready_i(mrdy), .sr_we_o(sr_we), .sr_o(sr_o),
    .pc_we_o(pc_we), .pc_o(pc_o), .sp_we_o(sp_we), .sp_o(sp_o)
  );

  function automatic logic [XLEN-1:0] tbl(logic [XLEN-1:0] a);
    return ~a ^ 32'h0000_5A00;
  endfunction

  // memory model: ready after wait_n stall cycles, one cycle wide
  always @(negedge clk) begin
    if (mrdy) begin
      mrdy = 1'b0;
      wcnt = 0;
    end else if (mreq) begin
      if (wcnt >= wait_n) begin
        mrdy   = 1'b1;
        mrdata = tbl(maddr);
      end else wcnt++;
    end
  end

  // observer, away from both edges
  always begin
    @(negedge clk);
    #2;
    if (mreq && mrdy && mwe && wr_n < 4) begin wr_a[wr_n] = maddr; wr_d[wr_n] = mwdata; wr_n++; end
    if (mreq && mrdy && !mwe && rd_n < 4) begin rd_a[rd_n] = maddr; rd_n++; end
    if (sp_we && sp_n < 4) begin sp_l[sp_n] = sp_o; sp_n++; end
    if (sr_we && sr_n < 4) begin sr_l[sr_n] = sr_o; sr_n++; end
    if (pc_we && pc_n < 4) begin pc_l[pc_n] = pc_o; pc_n++; end
    if (drop) drop_n++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clr_logs();
    wr_n = 0; sp_n = 0; sr_n = 0; pc_n = 0; rd_n = 0; drop_n = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !mreq, "R1", "busy/req after reset", {30'b0, busy, mreq}, '0);
    chk(!sr_we && !pc_we && !sp_we, "R1", "write strobes after reset",
        {29'b0, sr_we, pc_we, sp_we}, '0);
  endtask

  task automatic t_no_decode();
    bit bad = 1'b0;
    clr_logs();
    @(negedge clk); #1; req = 1'b1; dv = 1'b0; lvl = 4'hF; vec = 8'h11;
    repeat (8) begin
      @(negedge clk); #3;
      if (busy || mreq || drop) bad = 1'b1;
    end
    chk(!bad, "R10", "request without decode valid", {31'b0, bad}, '0);
    req = 1'b0;
  endtask

  task automatic t_entry(input logic [3:0] l, input logic [7:0] v,
                         input logic [XLEN-1:0] pc, input logic [XLEN-1:0] s,
                         input logic [XLEN-1:0] stk, input logic [XLEN-1:0] vb,
                         input int wn, input bit churn);
    logic [XLEN-1:0] va, sr_exp;
    int n = 0;
    clr_logs();
    wait_n = wn;
    va     = vb + {22'b0, v, 2'b00};
    sr_exp = (s & ~32'h0000_00F0) | {24'b0, l, 4'b0};
    @(negedge clk); #1;
    dv = 1'b1; req = 1'b1; lvl = l; vec = v; dpc = pc; sr = s; sp = stk; vbase = vb;
    #2;
    chk(drop == 1'b1, "R2", "drop on accept", {31'b0, drop}, 1);
    @(negedge clk); #1;
    if (!churn) begin dv = 1'b0; req = 1'b0; end
    #2;
    chk(busy == 1'b1, "R2", "busy after accept", {31'b0, busy}, 1);
    while (pc_n == 0 && n < 60) begin
      if (churn) begin
        @(negedge clk); #1;
        lvl = ~lvl; vec = vec + 8'd37; dpc = dpc ^ 32'hFFFF_0000;
        sr = ~sr; sp = sp + 32'h100;
        #2;
      end else begin
        @(negedge clk); #3;
      end
      n++;
    end
    dv = 1'b0; req = 1'b0;
    @(negedge clk); #3;
    chk(busy == 1'b0, "R2", "busy low after PC load", {31'b0, busy}, 0);
    chk(wr_n == 2, "R3", "stack write count", wr_n, 2);
    chk(wr_a[0] == stk - 4 && wr_d[0] == s, "R3", "SR push addr", wr_a[0], stk - 4);
    chk(wr_d[0] == s, "R3", "SR push data", wr_d[0], s);
    chk(wr_a[1] == stk - 8, "R4", "PC push addr", wr_a[1], stk - 8);
    chk(wr_d[1] == pc, "R4", "PC push data", wr_d[1], pc);
    chk(sp_n == 2 && sp_l[0] == stk - 4, "R5", "first SP update", sp_l[0], stk - 4);
    chk(sp_n == 2 && sp_l[1] == stk - 8, "R5", "second SP update", sp_l[1], stk - 8);
    chk(sr_n == 1 && sr_l[0] == sr_exp, "R6", "SR mask update", sr_l[0], sr_exp);
    chk(rd_n == 1 && rd_a[0] == va, "R7", "vector address", rd_a[0], va);
    chk(pc_n == 1 && pc_l[0] == tbl(va), "R7", "handler PC", pc_l[0], tbl(va));
    if (churn)
      chk(drop_n == 1, "R9", "single drop while busy", drop_n, 1);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    clr_logs();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #3;
    t_reset();
    t_no_decode();
    // R3 R4 R5 R6 R7: no stalls
    t_entry(4'h5, 8'h0C, 32'h0000_2340, 32'h0000_0001, 32'h0000_8000, 32'h0000_0400, 0, 1'b0);
    // R8: stalled accesses, mask bits already set, top vector
    t_entry(4'hF, 8'hFF, 32'h8000_1002, 32'hFFFF_FFFF, 32'h0010_0000, 32'h0000_1000, 3, 1'b0);
    // level 0 clears the mask field, stack near top of memory
    t_entry(4'h0, 8'h00, 32'h0000_0010, 32'h0000_00F3, 32'hFFFF_FFF0, 32'h0000_0000, 1, 1'b0);
    // R9: inputs churn throughout the entry
    t_entry(4'hA, 8'h40, 32'h1234_5678, 32'h0000_0F0F, 32'h0020_0000, 32'h0004_0000, 2, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule